// File: doc/BRIEF.md
# Physical Register Rename Unit

This block maps architectural register numbers onto a pool of physical registers for a core that renames one instruction per cycle and executes out of order. It holds a speculative map and a committed map, each with one entry per architectural register, and a first-in first-out pool of unused physical tags. For each instruction it accepts, it translates both source registers through the speculative map. If the instruction writes a register, it also takes a fresh tag from the head of the pool and reports the tag the destination held before. No register values pass through the block. Only tags move.

The previous tag travels with the instruction in the reorder buffer. When that instruction commits, the reorder buffer sends the new and previous tags back. The previous tag then joins the tail of the pool, and the committed map records the new tag. At every branch the block saves a copy of the speculative map and the pool's read pointer in a snapshot slot. A misprediction restores that copy and throws away every younger snapshot. An exception rebuilds the speculative state from the committed map. Because allocation and commit both follow program order, the pool's read pointer can be rewound to the position of the oldest uncommitted allocation. This returns every speculatively allocated tag to the pool.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i in both maps. The pool holds tags ARCH_REGS up to PHYS_REGS-1 in ascending order, so the first allocation returns tag ARCH_REGS.
- R2: The source tags `ren_ptag_a` and `ren_ptag_b` are read combinationally from the speculative map before the instruction's own destination update. A source equal to the destination therefore sees the older tag.
- R3: An accepted instruction with `ren_has_dst`=1 receives the tag at the head of the pool on `ren_ptag_dst`, and the speculative map entry of `ren_dst` takes that tag. `ren_ptag_old` shows the entry's value before the update, and it always differs from the new tag.
- R4: An instruction with `ren_has_dst`=0 takes nothing from the pool, leaves the map unchanged, and drives `ren_ptag_dst` and `ren_ptag_old` to 0.
- R5: A commit (`cm_valid`=1) appends `cm_ptag_old` to the tail of the pool and writes `cm_ptag_new` into the committed map entry of `cm_dst`. A tag freed this way is handed out again only after every tag ahead of it in the pool.
- R6: `ren_ready` is 0 for an instruction with a destination while the pool is empty. An instruction without a destination is still accepted.
- R7: An accepted instruction with `ren_is_branch`=1 is given snapshot slot `ren_snap_id`. Slots are handed out in circular order. A snapshot holds the map and pool state after the branch's own rename. `ren_ready` is 0 for a branch when the next slot in that order is still pending.
- R8: A misprediction (`br_valid`=1, `br_mispredict`=1) for slot s restores the speculative map from s. It rewinds the pool so that the tags allocated after the branch are handed out again in their original order. It discards s and every slot allocated after s, and the next branch gets slot s.
- R9: A correct resolution (`br_valid`=1, `br_mispredict`=0) frees its slot and leaves the speculative map unchanged.
- R10: `exc_flush`=1 copies the committed map into the speculative map and discards all snapshots, so the next branch gets slot 0. It returns to the pool every tag that was allocated but not committed, in allocation order and ahead of the tags that were already free.
- R11: In a cycle with a misprediction or an exception, `ren_ready` is 0 and the presented instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Instruction presented for renaming |
| ren_has_dst | input | 1 | Instruction writes a destination register |
| ren_is_branch | input | 1 | Instruction is a predicted branch |
| ren_src_a | input | $clog2(ARCH_REGS) | First source architectural register |
| ren_src_b | input | $clog2(ARCH_REGS) | Second source architectural register |
| ren_dst | input | $clog2(ARCH_REGS) | Destination architectural register |
| ren_ready | output | 1 | Instruction is accepted this cycle |
| ren_ptag_a | output | $clog2(PHYS_REGS) | Physical tag of first source |
| ren_ptag_b | output | $clog2(PHYS_REGS) | Physical tag of second source |
| ren_ptag_dst | output | $clog2(PHYS_REGS) | Newly allocated destination tag |
| ren_ptag_old | output | $clog2(PHYS_REGS) | Prior tag of the destination |
| ren_snap_id | output | $clog2(SNAPS) | Snapshot slot given to a branch |
| cm_valid | input | 1 | An instruction with a destination commits |
| cm_dst | input | $clog2(ARCH_REGS) | Architectural destination of the committing instruction |
| cm_ptag_new | input | $clog2(PHYS_REGS) | Tag the committing instruction allocated |
| cm_ptag_old | input | $clog2(PHYS_REGS) | Prior tag to release |
| br_valid | input | 1 | A branch resolves |
| br_snap_id | input | $clog2(SNAPS) | Slot of the resolving branch |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| exc_flush | input | 1 | An exception is taken |

## Verification
The bench builds the unit with ARCH_REGS=4, PHYS_REGS=8 and SNAPS=2. This leaves a pool of four tags and two snapshot slots. Both stall conditions are therefore reached after a handful of instructions, and so is a snapshot ring that has wrapped with a slot still pending. A four-entry pool also makes the tail wrap within a couple of commits. This brings into reach a freed tag that is reused behind others, and the exception rewind that must rebuild a pool whose storage has already wrapped.

// File: rtl/rn_pkg.sv
package rn_pkg;
   typedef enum logic [1:0] {
      RC_NONE   = 2'd0,
      RC_BRANCH = 2'd1,
      RC_EXCEPT = 2'd2
   } recover_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
   import rn_pkg::*;
#(
   parameter int unsigned ARCH_REGS = 32,
   parameter int unsigned PHYS_REGS = 64,
   localparam int unsigned PW    = $clog2(PHYS_REGS),
   localparam int unsigned DEPTH = PHYS_REGS - ARCH_REGS,
   localparam int unsigned FW    = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic          push,
   input  logic [PW-1:0] push_tag,
   input  logic          retire,
   input  recover_e      rc_kind,
   input  logic [FW-1:0] rc_head,
   output logic [PW-1:0] head_tag,
   output logic [FW-1:0] head_after,
   output logic          empty
);
   localparam int unsigned IW = FW - 1;

   logic [PW-1:0] pool_mem [DEPTH];
   logic [FW-1:0] head_q, tail_q, cmt_q, cmt_nxt, fl_count;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("free pool depth must be a power of two, at least 2");
   end

   assign fl_count   = tail_q - head_q;
   assign empty      = (fl_count == '0);
   assign head_tag   = pool_mem[head_q[IW-1:0]];
   assign head_after = head_q + FW'(pop);
   assign cmt_nxt    = cmt_q + FW'(retire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= FW'(DEPTH);
         cmt_q  <= '0;
         for (int i = 0; i < int'(DEPTH); i++) begin
            pool_mem[i] <= PW'(ARCH_REGS + i);
         end
      end else begin
         if (push) begin
            pool_mem[tail_q[IW-1:0]] <= push_tag;
            tail_q <= tail_q + 1'b1;
         end
         cmt_q <= cmt_nxt;
         case (rc_kind)
            RC_EXCEPT: head_q <= cmt_nxt;
            RC_BRANCH: head_q <= rc_head;
            default:   head_q <= head_after;
         endcase
      end
   end

   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R6
   AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fl_count <= FW'(DEPTH)); // R5
endmodule

// File: rtl/rn_snap_ctrl.sv
module rn_snap_ctrl #(
   parameter int unsigned SNAPS = 4,
   parameter int unsigned FW    = 6,
   localparam int unsigned SW   = $clog2(SNAPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          save,
   input  logic [FW-1:0] save_head,
   input  logic          resolve,
   input  logic [SW-1:0] resolve_id,
   input  logic          mispredict,
   input  logic          flush,
   output logic [SW-1:0] alloc_id,
   output logic          slot_free,
   output logic [FW-1:0] rc_head
);
   logic [SNAPS-1:0] valid_q, kill;
   logic [SW-1:0]    aptr_q, dist_a;
   logic [FW-1:0]    head_mem [SNAPS];

   initial begin
      assert (SNAPS >= 2 && (SNAPS & (SNAPS - 1)) == 0)
         else $error("snapshot count must be a power of two, at least 2");
   end

   assign alloc_id  = aptr_q;
   assign slot_free = !valid_q[aptr_q];
   assign rc_head   = head_mem[resolve_id];
   assign dist_a    = aptr_q - resolve_id;

   for (genvar g = 0; g < int'(SNAPS); g++) begin : g_kill
      logic [SW-1:0] dist_g;
      assign dist_g  = SW'(g) - resolve_id;
      assign kill[g] = (dist_a == '0) || (dist_g < dist_a);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         aptr_q  <= '0;
      end else if (flush) begin
         valid_q <= '0;
         aptr_q  <= '0;
      end else if (resolve && mispredict) begin
         valid_q <= valid_q & ~kill;
         aptr_q  <= resolve_id;
      end else begin
         for (int i = 0; i < int'(SNAPS); i++) begin
            if (save && aptr_q == SW'(i)) begin
               valid_q[i] <= 1'b1;
            end else if (resolve && resolve_id == SW'(i)) begin
               valid_q[i] <= 1'b0;
            end
         end
         if (save) begin
            aptr_q <= aptr_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (save) begin
         head_mem[aptr_q] <= save_head;
      end
   end

   AST_SNAP_SLOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      save |-> !valid_q[aptr_q]); // R7
   AST_RESOLVE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (resolve && !flush) |-> valid_q[resolve_id]); // R9
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
   import rn_pkg::*;
#(
   parameter int unsigned ARCH_REGS = 32,
   parameter int unsigned PHYS_REGS = 64,
   parameter int unsigned SNAPS     = 4,
   localparam int unsigned AW = $clog2(ARCH_REGS),
   localparam int unsigned PW = $clog2(PHYS_REGS),
   localparam int unsigned SW = $clog2(SNAPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_a,
   input  logic [AW-1:0] rd_b,
   input  logic [AW-1:0] rd_d,
   output logic [PW-1:0] rd_a_tag,
   output logic [PW-1:0] rd_b_tag,
   output logic [PW-1:0] rd_d_tag,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_arch,
   input  logic [PW-1:0] wr_tag,
   input  logic          save,
   input  logic [SW-1:0] save_id,
   input  recover_e      rc_kind,
   input  logic [SW-1:0] rc_id,
   input  logic          cm_en,
   input  logic [AW-1:0] cm_arch,
   input  logic [PW-1:0] cm_tag
);
   typedef logic [ARCH_REGS-1:0][PW-1:0] map_t;

   map_t spec_q, spec_upd, cmt_q, cmt_nxt;
   map_t snap_q [SNAPS];

   initial begin
      assert ((ARCH_REGS & (ARCH_REGS - 1)) == 0 && ARCH_REGS >= 2)
         else $error("architectural register count must be a power of two");
   end

   assign rd_a_tag = spec_q[rd_a];
   assign rd_b_tag = spec_q[rd_b];
   assign rd_d_tag = spec_q[rd_d];

   always_comb begin
      spec_upd = spec_q;
      if (wr_en) begin
         spec_upd[wr_arch] = wr_tag;
      end
   end

   always_comb begin
      cmt_nxt = cmt_q;
      if (cm_en) begin
         cmt_nxt[cm_arch] = cm_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(ARCH_REGS); i++) begin
            spec_q[i] <= PW'(i);
            cmt_q[i]  <= PW'(i);
         end
      end else begin
         cmt_q <= cmt_nxt;
         case (rc_kind)
            RC_EXCEPT: spec_q <= cmt_nxt;
            RC_BRANCH: spec_q <= snap_q[rc_id];
            default:   spec_q <= spec_upd;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (save) begin
         snap_q[save_id] <= spec_upd;
      end
   end

   AST_EXC_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_kind == RC_EXCEPT) |=> (spec_q == cmt_q)); // R10
   AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rc_kind == RC_NONE) |=> (spec_q[$past(wr_arch)] == $past(wr_tag))); // R3
endmodule

// File: rtl/rename_unit.sv
module rename_unit
   import rn_pkg::*;
#(
   parameter int unsigned ARCH_REGS = 32,
   parameter int unsigned PHYS_REGS = 64,
   parameter int unsigned SNAPS     = 4,
   localparam int unsigned AW = $clog2(ARCH_REGS),
   localparam int unsigned PW = $clog2(PHYS_REGS),
   localparam int unsigned SW = $clog2(SNAPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ren_valid,
   input  logic          ren_has_dst,
   input  logic          ren_is_branch,
   input  logic [AW-1:0] ren_src_a,
   input  logic [AW-1:0] ren_src_b,
   input  logic [AW-1:0] ren_dst,
   output logic          ren_ready,
   output logic [PW-1:0] ren_ptag_a,
   output logic [PW-1:0] ren_ptag_b,
   output logic [PW-1:0] ren_ptag_dst,
   output logic [PW-1:0] ren_ptag_old,
   output logic [SW-1:0] ren_snap_id,
   input  logic          cm_valid,
   input  logic [AW-1:0] cm_dst,
   input  logic [PW-1:0] cm_ptag_new,
   input  logic [PW-1:0] cm_ptag_old,
   input  logic          br_valid,
   input  logic [SW-1:0] br_snap_id,
   input  logic          br_mispredict,
   input  logic          exc_flush
);
   localparam int unsigned DEPTH = PHYS_REGS - ARCH_REGS;
   localparam int unsigned FW    = $clog2(DEPTH) + 1;

   initial begin
      assert (PHYS_REGS > ARCH_REGS)
         else $error("physical registers must outnumber architectural ones");
   end

   recover_e      rc_kind;
   logic          recovering, fire, alloc, save;
   logic          fl_empty, snap_free;
   logic [PW-1:0] head_tag, old_tag;
   logic [FW-1:0] head_after, snap_head;

   always_comb begin
      if (exc_flush)                      rc_kind = RC_EXCEPT;
      else if (br_valid && br_mispredict) rc_kind = RC_BRANCH;
      else                                rc_kind = RC_NONE;
   end

   assign recovering = (rc_kind != RC_NONE);
   assign ren_ready  = !recovering
                     && (!ren_has_dst || !fl_empty)
                     && (!ren_is_branch || snap_free);
   assign fire  = ren_valid && ren_ready;
   assign alloc = fire && ren_has_dst;
   assign save  = fire && ren_is_branch;

   assign ren_ptag_dst = ren_has_dst ? head_tag : '0;
   assign ren_ptag_old = ren_has_dst ? old_tag  : '0;

   rn_free_list #(
      .ARCH_REGS(ARCH_REGS),
      .PHYS_REGS(PHYS_REGS)
   ) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop       (alloc),
      .push      (cm_valid),
      .push_tag  (cm_ptag_old),
      .retire    (cm_valid),
      .rc_kind   (rc_kind),
      .rc_head   (snap_head),
      .head_tag  (head_tag),
      .head_after(head_after),
      .empty     (fl_empty)
   );

   rn_snap_ctrl #(
      .SNAPS(SNAPS),
      .FW   (FW)
   ) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .save      (save),
      .save_head (head_after),
      .resolve   (br_valid && !exc_flush),
      .resolve_id(br_snap_id),
      .mispredict(br_mispredict),
      .flush     (exc_flush),
      .alloc_id  (ren_snap_id),
      .slot_free (snap_free),
      .rc_head   (snap_head)
   );

   rn_map_table #(
      .ARCH_REGS(ARCH_REGS),
      .PHYS_REGS(PHYS_REGS),
      .SNAPS    (SNAPS)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_a    (ren_src_a),
      .rd_b    (ren_src_b),
      .rd_d    (ren_dst),
      .rd_a_tag(ren_ptag_a),
      .rd_b_tag(ren_ptag_b),
      .rd_d_tag(old_tag),
      .wr_en   (alloc),
      .wr_arch (ren_dst),
      .wr_tag  (head_tag),
      .save    (save),
      .save_id (ren_snap_id),
      .rc_kind (rc_kind),
      .rc_id   (br_snap_id),
      .cm_en   (cm_valid),
      .cm_arch (cm_dst),
      .cm_tag  (cm_ptag_new)
   );

   AST_FRESH_DST: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (ren_ptag_dst != ren_ptag_old)); // R3
   AST_MISPREDICT_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_kind == RC_BRANCH) |=> $past(!ren_ready)); // R11
endmodule

// File: tb/tb_rename_unit.sv
module tb_rename_unit;
   localparam int A  = 4;
   localparam int P  = 8;
   localparam int S  = 2;
   localparam int AW = $clog2(A);
   localparam int PW = $clog2(P);
   localparam int SW = $clog2(S);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ren_valid, ren_has_dst, ren_is_branch;
   logic [AW-1:0] ren_src_a, ren_src_b, ren_dst;
   logic          ren_ready;
   logic [PW-1:0] ren_ptag_a, ren_ptag_b, ren_ptag_dst, ren_ptag_old;
   logic [SW-1:0] ren_snap_id;
   logic          cm_valid;
   logic [AW-1:0] cm_dst;
   logic [PW-1:0] cm_ptag_new, cm_ptag_old;
   logic          br_valid, br_mispredict, exc_flush;
   logic [SW-1:0] br_snap_id;

   always #10 clk = ~clk;

   rename_unit #(.ARCH_REGS(A), .PHYS_REGS(P), .SNAPS(S)) dut (
      .clk(clk), .rst_n(rst_n),
      .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_is_branch(ren_is_branch),
      .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
      .ren_ready(ren_ready), .ren_ptag_a(ren_ptag_a), .ren_ptag_b(ren_ptag_b),
      .ren_ptag_dst(ren_ptag_dst), .ren_ptag_old(ren_ptag_old), .ren_snap_id(ren_snap_id),
      .cm_valid(cm_valid), .cm_dst(cm_dst), .cm_ptag_new(cm_ptag_new), .cm_ptag_old(cm_ptag_old),
      .br_valid(br_valid), .br_snap_id(br_snap_id), .br_mispredict(br_mispredict),
      .exc_flush(exc_flush)
   );

   typedef struct {
      int    a, b, d, o, s;
      string req;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;

   int   mmap [A];
   int   cmap [A];
   int   free_q[$];
   int   infl_q[$];
   bit   sv  [S];
   int   sseq[S];
   int   smap[S][A];
   int   sfree[S][$];
   int   sinfl[S][$];
   int   aptr = 0;
   int   seqc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      ren_valid = 0; ren_has_dst = 0; ren_is_branch = 0;
      ren_src_a = '0; ren_src_b = '0; ren_dst = '0;
      cm_valid = 0; cm_dst = '0; cm_ptag_new = '0; cm_ptag_old = '0;
      br_valid = 0; br_snap_id = '0; br_mispredict = 0; exc_flush = 0;
   endtask

   // driver: computes the expected rename result and queues it
   task automatic ren_op(input bit hd, input bit br, input int sa, input int sb,
                         input int sd, input string req);
      exp_t e;
      bit   rdy;
      @(posedge clk); #1;
      clear_inputs();
      ren_valid = 1; ren_has_dst = hd; ren_is_branch = br;
      ren_src_a = AW'(sa); ren_src_b = AW'(sb); ren_dst = AW'(sd);
      rdy = (!hd || free_q.size() > 0) && (!br || !sv[aptr]);
      if (rdy) begin
         e.a = mmap[sa]; e.b = mmap[sb];
         e.d = hd ? free_q[0] : 0;
         e.o = hd ? mmap[sd] : 0;
         e.s = br ? aptr : -1;
         e.req = req;
         if (hd) begin
            infl_q.push_back(free_q.pop_front());
            mmap[sd] = e.d;
         end
         if (br) begin
            sv[aptr] = 1; sseq[aptr] = seqc++;
            for (int i = 0; i < A; i++) smap[aptr][i] = mmap[i];
            sfree[aptr] = free_q; sinfl[aptr] = infl_q;
            aptr = (aptr + 1) % S;
         end
         q.push_back(e);
      end
      #4;
      chk(ren_ready == rdy, req, "ren_ready", int'(ren_ready), int'(rdy));
   endtask

   task automatic commit_op(input int sd, input int pn, input int po);
      @(posedge clk); #1;
      clear_inputs();
      cm_valid = 1; cm_dst = AW'(sd); cm_ptag_new = PW'(pn); cm_ptag_old = PW'(po);
      free_q.push_back(po);
      void'(infl_q.pop_front());
      cmap[sd] = pn;
   endtask

   task automatic resolve_op(input int id, input bit mis, input string req);
      @(posedge clk); #1;
      clear_inputs();
      br_valid = 1; br_snap_id = SW'(id); br_mispredict = mis;
      if (mis) begin
         ren_valid = 1; ren_has_dst = 1; ren_dst = 2'd1;
         for (int i = 0; i < A; i++) mmap[i] = smap[id][i];
         free_q = sfree[id]; infl_q = sinfl[id];
         for (int i = 0; i < S; i++) if (sv[i] && sseq[i] >= sseq[id]) sv[i] = 0;
         aptr = id;
         #4;
         chk(ren_ready == 1'b0, "R11", "ready in mispredict cycle", int'(ren_ready), 0);
      end else begin
         sv[id] = 0;
      end
   endtask

   task automatic exc_op();
      @(posedge clk); #1;
      clear_inputs();
      exc_flush = 1; ren_valid = 1; ren_has_dst = 1; ren_dst = 2'd3;
      for (int i = 0; i < A; i++) mmap[i] = cmap[i];
      free_q = {infl_q, free_q};
      infl_q = {};
      for (int i = 0; i < S; i++) sv[i] = 0;
      aptr = 0;
      #4;
      chk(ren_ready == 1'b0, "R11", "ready in exception cycle", int'(ren_ready), 0);
   endtask

   task automatic idle_op();
      @(posedge clk); #1;
      clear_inputs();
   endtask

   // monitor: pops and compares as the design accepts instructions
   always @(negedge clk) begin
      if (rst_n && ren_valid && ren_ready) begin
         if (q.size() == 0) begin
            chk(1'b0, "R11", "unexpected accept", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(int'(ren_ptag_a) == e.a, e.req, "src a tag", int'(ren_ptag_a), e.a);
            chk(int'(ren_ptag_b) == e.b, e.req, "src b tag", int'(ren_ptag_b), e.b);
            chk(int'(ren_ptag_dst) == e.d, e.req, "dst tag", int'(ren_ptag_dst), e.d);
            chk(int'(ren_ptag_old) == e.o, e.req, "old tag", int'(ren_ptag_old), e.o);
            if (e.s >= 0)
               chk(int'(ren_snap_id) == e.s, e.req, "snapshot slot", int'(ren_snap_id), e.s);
         end
      end
   end

   bit done = 0;
   initial begin
      #(20 * 5000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      clear_inputs();
      for (int i = 0; i < A; i++) begin mmap[i] = i; cmap[i] = i; end
      for (int i = A; i < P; i++) free_q.push_back(i);
      for (int i = 0; i < S; i++) sv[i] = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state seen combinationally without accepting anything
      ren_has_dst = 1; ren_dst = 2'd2; ren_src_a = 2'd3;
      #4;
      chk(int'(ren_ptag_dst) == A, "R1", "first free tag", int'(ren_ptag_dst), A);
      chk(int'(ren_ptag_old) == 2, "R1", "identity old", int'(ren_ptag_old), 2);
      chk(int'(ren_ptag_a) == 3, "R1", "identity src", int'(ren_ptag_a), 3);

      ren_op(0, 0, 0, 3, 0, "R4");     // no destination: zeros, nothing taken
      ren_op(1, 0, 1, 2, 1, "R2");     // src equals dst sees the older tag
      ren_op(1, 0, 1, 1, 1, "R3");
      ren_op(0, 1, 1, 0, 0, "R7");     // branch, slot 0
      ren_op(1, 0, 2, 0, 2, "R3");
      ren_op(1, 1, 3, 1, 3, "R7");     // branch with dst, slot 1, pool now empty
      ren_op(0, 1, 0, 0, 0, "R7");     // both slots pending: stall
      ren_op(1, 0, 0, 0, 0, "R6");     // pool empty: stall
      ren_op(0, 0, 2, 3, 0, "R6");     // no destination still proceeds
      resolve_op(1, 0, "R9");
      ren_op(0, 0, 3, 1, 0, "R9");     // map unchanged after correct resolve
      ren_op(0, 1, 0, 0, 0, "R7");     // ring wrapped onto pending slot 0
      resolve_op(0, 1, "R8");
      ren_op(1, 0, 2, 3, 2, "R8");     // reclaimed tags, restored map
      ren_op(0, 1, 1, 2, 0, "R8");     // next branch reuses slot 0
      commit_op(1, 4, 1);
      ren_op(1, 0, 3, 0, 3, "R5");
      ren_op(1, 0, 0, 1, 0, "R5");     // freed tag handed out last
      commit_op(1, 5, 4);
      exc_op();
      ren_op(1, 0, 0, 1, 0, "R10");
      ren_op(1, 1, 2, 3, 2, "R10");    // branch gets slot 0 again
      ren_op(1, 0, 3, 0, 3, "R10");
      ren_op(1, 0, 1, 2, 1, "R10");
      ren_op(1, 0, 0, 0, 0, "R6");     // pool exhausted again
      idle_op();
      idle_op();
      chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule